// File: doc/BRIEF.md
# Sigma-Delta Converter Digital Loop with CIC Decimator

This block is the digital side of a first-order sigma-delta converter. An external comparator compares the analog input with the voltage on an external RC integrator. On every modulator clock the block registers that one comparator bit. The registered bit leaves the block as a 1-bit feedback DAC that charges or discharges the integrator, which closes the modulation loop.

The same registered bit drives a three-stage cascaded integrator-comb decimator. A high bit counts as +1 and a low bit as −1. The integrators run at the modulator rate in wrap-around two's-complement arithmetic. They are 18 + 3·log2(RATIO) bits wide. A decimation counter fires once every RATIO clocks. On that clock the three comb stages, each with differential delay 1, compute a new value. That value is shifted down and clamped into a signed 18-bit sample, and a valid pulse lasting one clock goes with it. The filter gain is RATIO³, which is 2^18 at the default RATIO of 64. The shift down is therefore one bit, and only the positive full-scale extreme needs the clamp.

Top module: `sdm_loop_cic`

## Requirements
- R1: `dac_out` equals the value `cmp_in` had at the previous rising clock edge, whenever `rst` was low at that edge.
- R2: `valid_o` is high for exactly one clock at a time, and after reset it recurs every RATIO clocks (64 by default) with no gaps.
- R3: A constant high input settles to +131071 (0x1FFFF). A constant low input settles to −131072 (0x20000). The magnitude of the comb result never exceeds RATIO³.
- R4: A high comparator bit counts as +1 and a low bit as −1. Take any input pattern whose period divides RATIO and that contains k high bits in every RATIO consecutive bits. It settles to the value ((2k − RATIO)·RATIO²) >>> 1, clamped to the range −131072 … +131071. For example, alternating bits give 0 and the repeating pattern 1,1,1,0 gives +65536.
- R5: While `rst` is high at a rising edge, the design clears `dac_out`, `valid_o` and `sample_o` to 0 at that edge, whatever the value of `cmp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | External comparator result (1 means the input is above the integrator) |
| dac_out | output | 1 | Registered comparator bit, driven to the external integrator as a 1-bit DAC |
| sample_o | output | 18 | Signed decimated sample |
| valid_o | output | 1 | Pulse lasting one clock that marks a new `sample_o` |

## Verification
On a decimation clock the comb stages take their snapshot at the same edge at which the integrators keep accumulating the next bit and the feedback register captures a new comparator bit. The bench provokes this collision with patterns whose bits change continuously across the window boundaries, so the snapshot falls mid-pattern and not at a quiet point. It judges the result in two ways. The settled samples must match the closed-form density formula exactly, and the feedback output must keep tracking the comparator on every clock, including the decimation clocks.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  // Two's-complement step for one modulator bit: high -> +1, low -> -1
  function automatic logic signed [63:0] sdm_step64(input logic b);
    return b ? 64'sd1 : -64'sd1;
  endfunction
endpackage

// File: rtl/sdm_bit_capture.sv
module sdm_bit_capture (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in,
  output logic bit_q
);
  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= cmp_in;
  end
endmodule

// File: rtl/cic_integrators.sv
module cic_integrators #(
  parameter int ACC_W  = 36,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] acc_o
);
  import sdm_pkg::*;

  logic signed [ACC_W-1:0] acc_q [STAGES];
  logic signed [ACC_W-1:0] step;
  logic signed [63:0]      step64;

  always_comb begin
    step64 = sdm_step64(bit_i);
    step   = step64[ACC_W-1:0];
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_int
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) acc_q[k] <= '0;
        else     acc_q[k] <= acc_q[k] + step;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) acc_q[k] <= '0;
        else     acc_q[k] <= acc_q[k] + acc_q[k-1];
      end
    end
  end

  assign acc_o = acc_q[STAGES-1];
endmodule

// File: rtl/cic_decim_combs.sv
module cic_decim_combs #(
  parameter int ACC_W  = 36,
  parameter int STAGES = 3,
  parameter int RATIO  = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] integ_i,
  output logic signed [ACC_W-1:0] comb_o,
  output logic                    comb_vld
);
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0]        cnt_q;
  logic                    tick;
  logic signed [ACC_W-1:0] dly_q [STAGES];
  logic signed [ACC_W-1:0] chain [STAGES+1];

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign chain[0] = integ_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    assign chain[k+1] = chain[k] - dly_q[k];
    always_ff @(posedge clk) begin
      if (rst)       dly_q[k] <= '0;
      else if (tick) dly_q[k] <= chain[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      comb_o   <= '0;
      comb_vld <= 1'b0;
    end else begin
      comb_vld <= tick;
      if (tick) comb_o <= chain[STAGES];
    end
  end
endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
  parameter int ACC_W = 36,
  parameter int OUT_W = 18,
  parameter int GAIN_LOG2 = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] comb_i,
  input  logic                    vld_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o
);
  localparam int SHIFT   = GAIN_LOG2 + 1 - OUT_W;
  localparam int SH_R    = (SHIFT > 0) ? SHIFT : 0;
  localparam int SH_L    = (SHIFT < 0) ? -SHIFT : 0;
  localparam logic signed [ACC_W-1:0] MAXP = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINN = ACC_W'(-(64'sd1 <<< (OUT_W-1)));
  localparam logic signed [ACC_W-1:0] MAG  = ACC_W'(64'sd1 <<< GAIN_LOG2);

  logic signed [ACC_W-1:0] shifted;
  logic signed [OUT_W-1:0] clamped;

  always_comb begin
    shifted = (comb_i >>> SH_R) <<< SH_L;
    if (shifted > MAXP)      clamped = MAXP[OUT_W-1:0];
    else if (shifted < MINN) clamped = MINN[OUT_W-1:0];
    else                     clamped = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= vld_i;
      if (vld_i) sample_o <= clamped;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    vld_i |-> (comb_i <= MAG && comb_i >= -MAG)); // R3
endmodule

// File: rtl/sdm_loop_cic.sv
module sdm_loop_cic #(
  parameter int OUT_W  = 18,
  parameter int STAGES = 3,
  parameter int RATIO  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  output logic             dac_out,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int LOG2R     = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int GAIN_LOG2 = STAGES * LOG2R;
  localparam int ACC_W     = OUT_W + GAIN_LOG2;

  logic                    bit_q;
  logic signed [ACC_W-1:0] integ;
  logic signed [ACC_W-1:0] comb;
  logic                    comb_vld;
  logic signed [OUT_W-1:0] samp;

  sdm_bit_capture u_cap (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .bit_q(bit_q)
  );

  cic_integrators #(.ACC_W(ACC_W), .STAGES(STAGES)) u_int (
    .clk(clk), .rst(rst), .bit_i(bit_q), .acc_o(integ)
  );

  cic_decim_combs #(.ACC_W(ACC_W), .STAGES(STAGES), .RATIO(RATIO)) u_comb (
    .clk(clk), .rst(rst), .integ_i(integ), .comb_o(comb), .comb_vld(comb_vld)
  );

  cic_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .GAIN_LOG2(GAIN_LOG2)) u_scale (
    .clk(clk), .rst(rst), .comb_i(comb), .vld_i(comb_vld),
    .sample_o(samp), .valid_o(valid_o)
  );

  assign dac_out  = bit_q;
  assign sample_o = samp;

  // strobe spacing checker
  int   gap_q;
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (valid_o) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1;
    end
  end

  AST_DAC_TRACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dac_out == $past(cmp_in)); // R1
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && seen_q) |-> gap_q == RATIO - 1); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R2
  AST_RST_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!valid_o && !dac_out && sample_o == '0)); // R5
endmodule

// File: tb/sim_sdm_loop_cic.sv
module sim_sdm_loop_cic;
  localparam int R    = 64;
  localparam int OW   = 18;
  localparam longint MAXP = 131071;
  localparam longint MINN = -131072;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_in = 1'b0;
  logic dac_out, valid_o;
  logic [OW-1:0] sample_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sdm_loop_cic u0 (
    .clk(clk), .rst(rst), .cmp_in(cmp_in),
    .dac_out(dac_out), .sample_o(sample_o), .valid_o(valid_o)
  );

  // edge-side bookkeeping
  logic   cap_cmp = 1'b0;
  logic   rst_at_edge = 1'b1;
  longint cyc = 0;
  always @(posedge clk) begin
    cap_cmp     <= cmp_in;
    rst_at_edge <= rst;
    cyc         <= cyc + 1;
  end

  longint last_v = 0;
  bit     have_last = 0;
  longint last_sample = 0;

  always @(negedge clk) begin
    if (rst_at_edge) begin
      have_last = 0;
    end else begin
      tests++;
      if (dac_out !== cap_cmp) begin
        fails++;
        $display("FAIL R1 dac_out=%0b expected=%0b", dac_out, cap_cmp);
      end
      if (valid_o) begin
        last_sample = longint'($signed(sample_o));
        if (have_last) begin
          tests++;
          if (cyc - last_v != R) begin
            fails++;
            $display("FAIL R2 strobe gap=%0d expected=%0d", cyc - last_v, R);
          end
        end
        have_last = 1;
        last_v = cyc;
      end
    end
  end

  function automatic longint expect_val(int ones_in_pat, int per);
    longint k, s, v;
    k = longint'(ones_in_pat) * (R / per);
    s = (2 * k - R) * R * R;
    v = s >>> 1;
    if (v > MAXP) v = MAXP;
    if (v < MINN) v = MINN;
    return v;
  endfunction

  task automatic run_pat(input logic [63:0] pat, input int per, input string tag);
    int ones = 0;
    longint exp_v;
    for (int i = 0; i < per; i++) ones += int'(pat[i]);
    for (int c = 0; c < 12 * R; c++) begin
      @(negedge clk);
      cmp_in = pat[c % per];
    end
    @(negedge clk);
    exp_v = expect_val(ones, per);
    tests++;
    if (last_sample != exp_v) begin
      fails++;
      $display("FAIL %s period=%0d ones=%0d actual=%0d expected=%0d",
               tag, per, ones, last_sample, exp_v);
    end
  endtask

  task automatic check_reset_state(input string tag);
    tests++;
    if (dac_out !== 1'b0 || valid_o !== 1'b0 || sample_o !== '0) begin
      fails++;
      $display("FAIL %s dac=%0b valid=%0b sample=%0h expected 0/0/0",
               tag, dac_out, valid_o, sample_o);
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd13579);
    rst = 1'b1;
    cmp_in = 1'b1;           // R5: a high comparator must not reach dac_out in reset
    repeat (5) @(negedge clk);
    check_reset_state("R5 initial reset");
    rst = 1'b0;

    run_pat(64'h1, 1, "R3 all-high");
    run_pat(64'h0, 1, "R3 all-low");
    run_pat(64'h1, 2, "R4 alternating");
    run_pat(64'h7, 4, "R4 pattern 1110");
    run_pat(64'h1, 8, "R4 one high in eight");

    for (int n = 0; n < 8; n++) begin
      int per;
      logic [63:0] pat;
      per = 1 << ($urandom % 7);
      pat = {$urandom, $urandom};
      run_pat(pat, per, "R4 random density");
    end

    run_pat(64'h1, 1, "R3 all-high again");
    @(negedge clk);
    rst = 1'b1;
    cmp_in = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R5 mid-run reset");
    rst = 1'b0;
    run_pat(64'h0, 1, "R3 all-low after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule